// File: doc/BRIEF.md
# DMA Request Arbiter with Interrupt Status

This block sits between sixteen peripheral DMA request lines and eight DMA channels that share one bus master. Each request line comes in two forms, a single-transfer request and a burst request, and both forms are brought into the clock domain through a two-flop synchroniser. A 4-bit source-select field for each channel picks which of the sixteen lines drives that channel. A per-channel enable bit then decides whether the channel may request the master at all.

When the master is free, the block grants the lowest-numbered enabled channel that is requesting. It reports whether that channel asked for a burst or a single transfer, and keeps the grant until the channel engine signals the end of that transfer. The block also holds per-channel completion and error status. Each kind has a raw view that ignores the masks, a mask register and a masked view. Raw bits are cleared by writing ones to them. One interrupt output is raised while any masked bit is set.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, gnt_valid, gnt_burst, gnt_chan and irq are 0, and every register address reads 0.
- R2: A request-line change reaches the grant outputs on the third rising edge after the change, because of the two synchroniser stages and the grant register. It is not visible on the second edge.
- R3: When the master is free, the enabled requesting channel with the lowest number is granted. Channel 0 has the highest priority and channel 7 the lowest.
- R4: While gnt_valid is 1, the grant (channel and burst flag) does not change until xfer_done is sampled high. On that edge gnt_valid drops to 0, and arbitration resumes on the following edge.
- R5: Channel n requests when its enable bit n (address 0) is 1 and either the single or the burst form of line src[4n+3:4n] (address 1) is high. A channel whose enable bit is 0 is never granted.
- R6: gnt_burst is 1 when the burst form of the granted channel's line was high at grant time. It stays stable for the whole grant. gnt_chan and gnt_burst are 0 while gnt_valid is 0.
- R7: A high bit on evt_done or evt_err sets the matching bit of the raw completion status (address 2) or the raw error status (address 3), whatever the masks hold. The bit stays set until it is cleared.
- R8: Writing to address 2 or 3 clears each raw bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. When a clear and an event for the same bit fall in the same cycle, the bit stays set.
- R9: Address 6 reads raw completion AND completion mask (mask at address 4). Address 7 reads raw error AND error mask (mask at address 5). irq is 1 exactly when either masked value is non-zero.
- R10: Addresses 0, 1, 4 and 5 read back what was last written to them. Addresses 6 and 7 are read-only, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preq_single | input | 16 | Asynchronous single-transfer request per line |
| preq_burst | input | 16 | Asynchronous burst request per line |
| xfer_done | input | 1 | Granted channel finished its burst or single transfer |
| gnt_valid | output | 1 | Master is granted to a channel |
| gnt_burst | output | 1 | Granted request was a burst |
| gnt_chan | output | 3 | Granted channel number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_done | input | 8 | Per-channel completion event pulses |
| evt_err | input | 8 | Per-channel error event pulses |
| irq | output | 1 | Combined interrupt |

## Verification
A request change driven between edges is expected on the grant outputs three rising edges later. A release after xfer_done shows one edge later, and the next grant one edge after that. Register writes and status events take effect on the next edge. Reads are combinational and irq follows the status in the same cycle. The bench stores each expected value with the cycle number in which it becomes due, including a deliberate "not yet" value one edge early. A monitor compares each item in the middle of the high clock phase of exactly that cycle, so no check depends on process ordering at an edge.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH   = 8,
  parameter int NLINE = 16,
  parameter int DW    = 32,
  localparam int CHW  = $clog2(NCH),
  localparam int SELW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] preq_single,
  input  logic [NLINE-1:0] preq_burst,
  input  logic             xfer_done,
  output logic             gnt_valid,
  output logic             gnt_burst,
  output logic [CHW-1:0]   gnt_chan,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NCH-1:0]   evt_done,
  input  logic [NCH-1:0]   evt_err,
  output logic             irq
);

  localparam int SRCW = NCH * SELW;

  logic [NLINE-1:0] s1_single, s2_single, s1_burst, s2_burst;
  logic [NCH-1:0]   ch_en, done_raw, err_raw, done_mask, err_mask;
  logic [SRCW-1:0]  src_sel;
  logic [NCH-1:0]   ch_req, ch_bst;
  logic             win_any;
  logic [CHW-1:0]   win_ch;
  logic [NCH-1:0]   done_clr, err_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_single <= '0;
      s2_single <= '0;
      s1_burst  <= '0;
      s2_burst  <= '0;
    end else begin
      s1_single <= preq_single;
      s2_single <= s1_single;
      s1_burst  <= preq_burst;
      s2_burst  <= s1_burst;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_map
    logic [SELW-1:0] line;
    assign line      = src_sel[c*SELW +: SELW];
    assign ch_req[c] = ch_en[c] & (s2_single[line] | s2_burst[line]);
    assign ch_bst[c] = s2_burst[line];
  end

  always_comb begin
    win_any = 1'b0;
    win_ch  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ch_req[i]) begin
        win_any = 1'b1;
        win_ch  = CHW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_burst <= 1'b0;
      gnt_chan  <= '0;
    end else if (gnt_valid) begin
      if (xfer_done) begin
        gnt_valid <= 1'b0;
        gnt_burst <= 1'b0;
        gnt_chan  <= '0;
      end
    end else if (win_any) begin
      gnt_valid <= 1'b1;
      gnt_burst <= ch_bst[win_ch];
      gnt_chan  <= win_ch;
    end
  end

  assign done_clr = (reg_wr && reg_addr == 3'd2) ? reg_wdata[NCH-1:0] : '0;
  assign err_clr  = (reg_wr && reg_addr == 3'd3) ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en     <= '0;
      src_sel   <= '0;
      done_mask <= '0;
      err_mask  <= '0;
      done_raw  <= '0;
      err_raw   <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0:    ch_en     <= reg_wdata[NCH-1:0];
          3'd1:    src_sel   <= reg_wdata[SRCW-1:0];
          3'd4:    done_mask <= reg_wdata[NCH-1:0];
          3'd5:    err_mask  <= reg_wdata[NCH-1:0];
          default: ;
        endcase
      end
      done_raw <= (done_raw & ~done_clr) | evt_done;
      err_raw  <= (err_raw & ~err_clr) | evt_err;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[NCH-1:0]  = ch_en;
      3'd1: reg_rdata[SRCW-1:0] = src_sel;
      3'd2: reg_rdata[NCH-1:0]  = done_raw;
      3'd3: reg_rdata[NCH-1:0]  = err_raw;
      3'd4: reg_rdata[NCH-1:0]  = done_mask;
      3'd5: reg_rdata[NCH-1:0]  = err_mask;
      3'd6: reg_rdata[NCH-1:0]  = done_raw & done_mask;
      3'd7: reg_rdata[NCH-1:0]  = err_raw & err_mask;
      default: ;
    endcase
  end

  assign irq = |((done_raw & done_mask) | (err_raw & err_mask));

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gnt_valid,
  input logic           gnt_burst,
  input logic [CHW-1:0] gnt_chan,
  input logic           xfer_done,
  input logic           reg_wr,
  input logic [2:0]     reg_addr,
  input logic [NCH-1:0] evt_done,
  input logic [NCH-1:0] done_raw,
  input logic [NCH-1:0] done_mask,
  input logic [NCH-1:0] err_mask,
  input logic           irq
);

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !xfer_done |=> gnt_valid && $stable(gnt_chan) && $stable(gnt_burst)); // R4

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && xfer_done |=> !gnt_valid); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> gnt_chan == '0 && !gnt_burst); // R6

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done_raw & $past(evt_done)) == $past(evt_done)); // R8

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd2) && evt_done == '0 |=> $stable(done_raw)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_mask == '0 && err_mask == '0 |-> !irq); // R9

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH), .CHW(CHW)) u_chk (.*);

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] preq_single = '0, preq_burst = '0;
  logic        xfer_done = 1'b0;
  logic        gnt_valid, gnt_burst;
  logic [2:0]  gnt_chan;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  evt_done = '0, evt_err = '0;
  logic        irq;

  dma_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .preq_single(preq_single), .preq_burst(preq_burst),
    .xfer_done(xfer_done), .gnt_valid(gnt_valid), .gnt_burst(gnt_burst), .gnt_chan(gnt_chan),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done(evt_done), .evt_err(evt_err), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic push(int dly, int kind, logic [31:0] exp, string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_gnt(int dly, bit v, bit b, int ch, string tag);
    push(dly, 0, {27'b0, v, b, 3'(ch)}, tag);
  endtask

  task automatic exp_irq(bit v, string tag);
    push(1, 2, {31'b0, v}, tag);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    push(1, 1, exp, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_evt(logic [7:0] dn, logic [7:0] er);
    @(negedge clk);
    evt_done = dn; evt_err = er;
    @(negedge clk);
    evt_done = '0; evt_err = '0;
  endtask

  // monitor: compares queued items in mid high phase of their due cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #(CLK_PERIOD/2 - 1);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          logic [31:0] act;
          case (q[i].kind)
            0:       act = {27'b0, gnt_valid, gnt_burst, gnt_chan};
            1:       act = reg_rdata;
            default: act = {31'b0, irq};
          endcase
          checks++;
          if (act !== q[i].exp || q[i].due != cyc) begin
            failures++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", q[i].tag, q[i].kind, act, q[i].exp);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    exp_gnt(1, 0, 0, 0, "R1 grant idle");
    exp_irq(0, "R1 irq low");
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 register zero");

    wr(0, 32'hFF);
    wr(1, 32'hFEDCBA98);
    rd(0, 32'hFF, "R10 enable readback");
    rd(1, 32'hFEDCBA98, "R10 select readback");

    tick(1);
    preq_single = 16'h1000;
    exp_gnt(2, 0, 0, 0, "R2 not yet at second edge");
    exp_gnt(3, 1, 0, 4, "R2 R5 grant via line 12");
    tick(3);
    preq_single = '0;
    preq_burst  = 16'h0400;
    exp_gnt(4, 1, 0, 4, "R4 grant held against higher priority");
    tick(4);
    xfer_done = 1'b1;
    exp_gnt(1, 0, 0, 0, "R4 release on xfer_done");
    exp_gnt(2, 1, 1, 2, "R6 burst grant channel 2");
    tick(1);
    xfer_done = 1'b0;
    tick(1);
    preq_burst = '0;
    exp_gnt(4, 1, 1, 2, "R6 burst flag stable");
    tick(4);

    preq_single = 16'h8200;
    tick(3);
    xfer_done = 1'b1;
    exp_gnt(1, 0, 0, 0, "R4 release");
    exp_gnt(2, 1, 0, 1, "R3 channel 1 over channel 7");
    tick(1);
    xfer_done = 1'b0;
    tick(1);
    preq_single = 16'h8000;
    tick(3);
    xfer_done = 1'b1;
    exp_gnt(2, 1, 0, 7, "R3 lowest priority served alone");
    tick(1);
    xfer_done = 1'b0;

    wr(0, 32'h7F);
    xfer_done = 1'b1;
    exp_gnt(1, 0, 0, 0, "R4 release");
    exp_gnt(2, 0, 0, 0, "R5 disabled channel 7");
    exp_gnt(3, 0, 0, 0, "R5 disabled channel 7 later");
    tick(1);
    xfer_done = 1'b0;

    wr(1, 32'hFEDCBA93);
    preq_single = 16'h8008;
    exp_gnt(3, 1, 0, 0, "R5 remapped channel 0 to line 3");
    tick(3);
    preq_single = '0;
    tick(3);
    xfer_done = 1'b1;
    exp_gnt(2, 0, 0, 0, "R4 idle after last release");
    tick(1);
    xfer_done = 1'b0;

    pulse_evt(8'h05, 8'h00);
    rd(2, 32'h05, "R7 raw done set with mask clear");
    exp_irq(0, "R9 no irq while masked");
    wr(4, 32'h04);
    rd(6, 32'h04, "R9 masked done");
    exp_irq(1, "R9 irq from masked done");
    wr(2, 32'h04);
    rd(2, 32'h01, "R8 write one clears");
    exp_irq(0, "R9 irq drops after clear");
    wr(2, 32'h00);
    rd(2, 32'h01, "R8 write zero keeps");

    pulse_evt(8'h00, 8'h02);
    rd(3, 32'h02, "R7 raw error set");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h02; evt_err = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; evt_err = '0;
    rd(3, 32'h02, "R8 event wins over clear");
    wr(3, 32'h02);
    rd(3, 32'h00, "R8 error cleared");

    wr(5, 32'h80);
    pulse_evt(8'h00, 8'h80);
    rd(7, 32'h80, "R9 masked error");
    exp_irq(1, "R9 irq from error");
    wr(7, 32'h0);
    rd(7, 32'h80, "R10 masked view read-only");
    rd(4, 32'h04, "R10 mask readback");
    rd(1, 32'hFEDCBA93, "R10 select readback after rewrite");

    tick(4);
    if (q.size() != 0) begin
      failures += q.size();
      $display("FAIL pending items actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule